// File: doc/BRIEF.md
# Cumulative-Sum Change Detector

This block watches a stream of unsigned samples for a lasting upward shift in their level. It keeps one running statistic. Each accepted sample adds its own value to the statistic and subtracts a drift term. The statistic never falls below zero and never wraps at the top. When the statistic rises above a programmable threshold, a sticky alarm flag is raised.

The drift term is built from two estimates that the surrounding logic loads ahead of time. The first is the expected sample level before a shift. The second is the level expected after it, scaled by a fractional weight. Both estimates, the weight and the threshold are plain input ports. A clear strobe drops the alarm and zeroes the statistic. The datapath takes one sample per clock with two register stages, and one of those stages holds the product of the weight and the post-shift estimate.

Top module: `cusum_detector`

## Requirements
- R1: After a synchronous active-low reset, `stat_o` is 0 and `alarm_o` is 0.
- R2: For each accepted sample X, the statistic becomes max(0, S + X − D). Here D = `base_i` + floor(`weight_i` × `post_i` / 2^WT_FRAC), and `weight_i` is unsigned with WT_FRAC (default 4) fractional bits.
- R3: An update whose sample is not larger than the drift never raises the statistic, and a result below zero is held at 0.
- R4: The statistic saturates at 2^STAT_W − 1 and does not wrap. An update whose sample is at least the drift never lowers it.
- R5: A sample taken with `smp_vld_i` high at clock edge k shows on `stat_o` after edge k+1. Without an accepted sample, the statistic holds its value.
- R6: `alarm_o` rises after the update whose new statistic is strictly greater than the threshold presented with that sample. A statistic equal to the threshold does not raise it.
- R7: Once raised, `alarm_o` stays high until a clear, even when the statistic falls below the threshold or to zero.
- R8: With `clr_i` high at an edge, `stat_o` and `alarm_o` are 0 after that edge. This holds even when a sample update falls due at the same edge; that update is dropped.
- R9: The estimates, weight and threshold are sampled at the edge where the sample is taken. Changing them while no sample is taken leaves `stat_o` and `alarm_o` unchanged.
- R10: Samples on consecutive cycles are each applied in order, one per cycle, with no gap required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | DATA_W | Unsigned sample value |
| base_i | input | DATA_W | Expected level before a shift |
| post_i | input | DATA_W | Expected level after a shift |
| weight_i | input | WT_W | Fractional weight on `post_i` |
| thr_i | input | STAT_W | Alarm threshold |
| clr_i | input | 1 | Clear alarm and statistic |
| stat_o | output | STAT_W | Current statistic |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
Two things can meet at the same clock edge: a clear, and the update of a sample already in the second register stage. That update may also be the one that would cross the threshold. The bench provokes this in two ways. It presents a large sample and raises the clear on the very next cycle, and in the random phase it drops clear strobes among back-to-back samples. In both cases the bench expects a zero statistic and a low alarm after the edge, and normal accumulation from the following sample onward.

// File: rtl/cusum_pkg.sv
// Package: shared types for the cumulative-sum detector.
// Holds the selector that names which branch of the clamp an update took.
package cusum_pkg;

    typedef enum logic [1:0] {
        CLAMP_PASS  = 2'd0,
        CLAMP_FLOOR = 2'd1,
        CLAMP_CEIL  = 2'd2
    } clamp_sel_e;

endpackage

// File: rtl/cusum_drift.sv
// Module: cusum_drift
// Builds the drift term one register stage after the parameters are sampled:
// drift = base + (weight * post) >> WT_FRAC. The product and the base are
// registered on every clock, so the drift lines up with the sample stage.
// Assumes the parameters are unsigned and that DRIFT_W = DATA_W + WT_W + 1.
module cusum_drift #(
    parameter int DATA_W  = 16,
    parameter int WT_W    = 8,
    parameter int WT_FRAC = 4,
    parameter int DRIFT_W = DATA_W + WT_W + 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [DATA_W-1:0]  base_i,
    input  logic [DATA_W-1:0]  post_i,
    input  logic [WT_W-1:0]    weight_i,
    output logic [DRIFT_W-1:0] drift_o
);
    localparam int PROD_W = DATA_W + WT_W;

    logic [PROD_W-1:0] prod_q;
    logic [DATA_W-1:0] base_q;
    logic [PROD_W-1:0] prod_scaled;

    // Register the weighted product and the base estimate.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prod_q <= '0;
            base_q <= '0;
        end else begin
            prod_q <= PROD_W'(weight_i) * PROD_W'(post_i);
            base_q <= base_i;
        end
    end

    // Drop the fractional bits of the weight and add the base estimate.
    always_comb begin
        prod_scaled = prod_q >> WT_FRAC;
        drift_o     = {1'b0, prod_scaled} + DRIFT_W'(base_q);
    end

endmodule

// File: rtl/cusum_ingest.sv
// Module: cusum_ingest
// First pipeline stage: captures the sample strobe, the sample value and
// the threshold that belongs to it. Assumes one sample per clock at most.
module cusum_ingest #(
    parameter int DATA_W = 16,
    parameter int STAT_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              smp_vld_i,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [STAT_W-1:0] thr_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] smp_o,
    output logic [STAT_W-1:0] thr_o
);
    // Hold the sample and its threshold for the accumulate stage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vld_o <= 1'b0;
            smp_o <= '0;
            thr_o <= '0;
        end else begin
            vld_o <= smp_vld_i;
            smp_o <= smp_i;
            thr_o <= thr_i;
        end
    end

endmodule

// File: rtl/cusum_accum.sv
// Module: cusum_accum
// Second pipeline stage: adds the sample, subtracts the drift and clamps the
// result to [0, 2^STAT_W-1]. A clear zeroes the statistic and beats an update.
// Assumes SUM_W is wider than STAT_W, DATA_W and DRIFT_W by a sign bit plus
// one guard bit.
module cusum_accum
    import cusum_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int STAT_W  = 24,
    parameter int DRIFT_W = 25
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clr_i,
    input  logic               upd_i,
    input  logic [DATA_W-1:0]  smp_i,
    input  logic [DRIFT_W-1:0] drift_i,
    output logic [STAT_W-1:0]  stat_o,
    output logic [STAT_W-1:0]  stat_nxt_o
);
    localparam int WIDE_W = (STAT_W > DRIFT_W) ? STAT_W : DRIFT_W;
    localparam int SUM_W  = WIDE_W + 2;
    localparam logic signed [SUM_W-1:0] SAT_LIM = SUM_W'({STAT_W{1'b1}});

    logic [STAT_W-1:0]       stat_q;
    logic signed [SUM_W-1:0] sum;
    clamp_sel_e              sel;

    // Form the signed candidate value S + X - D.
    always_comb begin
        sum = $signed(SUM_W'(stat_q)) + $signed(SUM_W'(smp_i))
            - $signed(SUM_W'(drift_i));
    end

    // Decide which clamp branch the candidate falls in.
    always_comb begin
        if (sum < 0)            sel = CLAMP_FLOOR;
        else if (sum > SAT_LIM) sel = CLAMP_CEIL;
        else                    sel = CLAMP_PASS;
    end

    // Produce the clamped next statistic.
    always_comb begin
        case (sel)
            CLAMP_FLOOR: stat_nxt_o = '0;
            CLAMP_CEIL:  stat_nxt_o = {STAT_W{1'b1}};
            default:     stat_nxt_o = sum[STAT_W-1:0];
        endcase
    end

    // Hold the statistic; clear first, then a due update.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    stat_q <= '0;
        else if (clr_i) stat_q <= '0;
        else if (upd_i) stat_q <= stat_nxt_o;
    end

    assign stat_o = stat_q;

    // R8
    clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (stat_q == '0));

    // R5
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!upd_i && !clr_i) |=> $stable(stat_q));

    // R4
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_i && !clr_i && (DRIFT_W'(smp_i) >= drift_i)) |=> (stat_q >= $past(stat_q)));

    // R3
    no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_i && !clr_i && (DRIFT_W'(smp_i) <= drift_i)) |=> (stat_q <= $past(stat_q)));

endmodule

// File: rtl/cusum_alarm.sv
// Module: cusum_alarm
// Sticky alarm: sets when an update's new statistic is strictly above the
// threshold captured with its sample; only a clear or reset drops it.
module cusum_alarm #(
    parameter int STAT_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [STAT_W-1:0] stat_nxt_i,
    input  logic [STAT_W-1:0] thr_i,
    output logic              alarm_o
);
    logic alarm_q;

    // Set on a crossing, clear on request; clear wins.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                             alarm_q <= 1'b0;
        else if (clr_i)                          alarm_q <= 1'b0;
        else if (upd_i && (stat_nxt_i > thr_i))  alarm_q <= 1'b1;
    end

    assign alarm_o = alarm_q;

    // R7
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alarm_q && !clr_i) |=> alarm_q);

    // R8
    clr_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !alarm_q);

endmodule

// File: rtl/cusum_detector.sv
// Module: cusum_detector (top)
// One-sided cumulative-sum change detector. Stage one captures the sample,
// its threshold and the weighted drift product; stage two updates the clamped
// statistic and the sticky alarm. Assumes parameter ports are quasi-static
// and are taken together with each sample.
module cusum_detector #(
    parameter int DATA_W  = 16,
    parameter int WT_W    = 8,
    parameter int WT_FRAC = 4,
    parameter int STAT_W  = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              smp_vld_i,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] post_i,
    input  logic [WT_W-1:0]   weight_i,
    input  logic [STAT_W-1:0] thr_i,
    input  logic              clr_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              alarm_o
);
    localparam int DRIFT_W = DATA_W + WT_W + 1;

    logic               s1_vld;
    logic [DATA_W-1:0]  s1_smp;
    logic [STAT_W-1:0]  s1_thr;
    logic [DRIFT_W-1:0] s1_drift;
    logic [STAT_W-1:0]  stat_nxt;

    cusum_ingest #(.DATA_W(DATA_W), .STAT_W(STAT_W)) ingest_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
        .thr_i(thr_i), .vld_o(s1_vld), .smp_o(s1_smp), .thr_o(s1_thr)
    );

    cusum_drift #(.DATA_W(DATA_W), .WT_W(WT_W), .WT_FRAC(WT_FRAC),
                  .DRIFT_W(DRIFT_W)) drift_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i), .post_i(post_i),
        .weight_i(weight_i), .drift_o(s1_drift)
    );

    cusum_accum #(.DATA_W(DATA_W), .STAT_W(STAT_W), .DRIFT_W(DRIFT_W)) accum_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .upd_i(s1_vld),
        .smp_i(s1_smp), .drift_i(s1_drift), .stat_o(stat_o),
        .stat_nxt_o(stat_nxt)
    );

    cusum_alarm #(.STAT_W(STAT_W)) alarm_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .upd_i(s1_vld),
        .stat_nxt_i(stat_nxt), .thr_i(s1_thr), .alarm_o(alarm_o)
    );

    // R6
    alarm_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(alarm_o) |-> (stat_o > $past(s1_thr)));

endmodule

// File: tb/cusum_detector_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// cycle model written from the requirements.
module cusum_detector_tb_top;
    localparam int DATA_W  = 16;
    localparam int WT_W    = 8;
    localparam int WT_FRAC = 4;
    localparam int STAT_W  = 24;
    localparam longint SMAX = (longint'(1) << STAT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vld = 1'b0;
    logic [DATA_W-1:0] smp = '0;
    logic [DATA_W-1:0] base = '0;
    logic [DATA_W-1:0] post = '0;
    logic [WT_W-1:0]   wt = '0;
    logic [STAT_W-1:0] thr = '0;
    logic              clr = 1'b0;
    logic [STAT_W-1:0] stat;
    logic              alarm;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    longint m_s = 0;
    bit     m_al = 1'b0;
    bit     p_v = 1'b0;
    longint p_x = 0;
    longint p_d = 0;
    longint p_t = 0;

    always #2.5 clk = ~clk;

    cusum_detector #(.DATA_W(DATA_W), .WT_W(WT_W), .WT_FRAC(WT_FRAC),
                     .STAT_W(STAT_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_i(smp),
        .base_i(base), .post_i(post), .weight_i(wt), .thr_i(thr),
        .clr_i(clr), .stat_o(stat), .alarm_o(alarm)
    );

    function automatic longint drift_of(longint b, longint p, longint w);
        return b + ((w * p) >> WT_FRAC);
    endfunction

    function automatic longint clamp_of(longint v);
        if (v < 0) return 0;
        if (v > SMAX) return SMAX;
        return v;
    endfunction

    task automatic check(string tag);
        n_chk++;
        if (longint'(stat) != m_s || alarm != m_al) begin
            n_fail++;
            $display("FAIL %s: stat=%0d alarm=%0d expected stat=%0d alarm=%0d",
                     tag, stat, alarm, m_s, m_al);
        end
    endtask

    task automatic check_val(string tag, longint s_exp, bit a_exp);
        n_chk++;
        if (longint'(stat) != s_exp || alarm != a_exp) begin
            n_fail++;
            $display("FAIL %s: stat=%0d alarm=%0d expected stat=%0d alarm=%0d",
                     tag, stat, alarm, s_exp, a_exp);
        end
    endtask

    // Drive one cycle from a negedge, update the model at the edge, compare after.
    task automatic step(bit v, longint x, bit c, string tag);
        vld = v; smp = DATA_W'(x); clr = c;
        @(posedge clk);
        if (c) begin
            m_s = 0; m_al = 1'b0;
        end else if (p_v) begin
            m_s = clamp_of(m_s + p_x - p_d);
            if (m_s > p_t) m_al = 1'b1;
        end
        p_v = v; p_x = x;
        p_d = drift_of(longint'(base), longint'(post), longint'(wt));
        p_t = longint'(thr);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        check_val("R1", 0, 1'b0);

        // R2 / R5: drift 100, sample 150; visible only after the second edge
        base = 16'd100; post = 16'd0; wt = 8'd0; thr = 24'hFFFFFF;
        step(1'b1, 150, 1'b0, "R5");
        check_val("R5", 0, 1'b0);
        step(1'b0, 0, 1'b0, "R2");
        check_val("R2", 50, 1'b0);

        // R3: result below zero floors at 0
        step(1'b1, 10, 1'b0, "R3");
        step(1'b0, 0, 1'b0, "R3");
        check_val("R3", 0, 1'b0);

        // R2: weight 1.5 on post 20 plus base 100 gives drift 130
        wt = 8'h18; post = 16'd20;
        step(1'b1, 200, 1'b0, "R2");
        step(1'b0, 0, 1'b0, "R2");
        check_val("R2", 70, 1'b0);

        // R9: parameter changes without a sample leave outputs alone
        base = 16'd9; wt = 8'hFF; post = 16'hFFFF; thr = 24'd1;
        step(1'b0, 0, 1'b0, "R9");
        step(1'b0, 0, 1'b0, "R9");
        check_val("R9", 70, 1'b0);

        // R6 / R7: equal to threshold stays low, one above sets, stays sticky
        base = 16'd100; wt = 8'd0; post = 16'd0; thr = 24'd70;
        step(1'b0, 0, 1'b1, "R8");
        step(1'b1, 170, 1'b0, "R6");
        step(1'b0, 0, 1'b0, "R6");
        check_val("R6", 70, 1'b0);
        step(1'b1, 101, 1'b0, "R6");
        step(1'b0, 0, 1'b0, "R6");
        check_val("R6", 71, 1'b1);
        step(1'b1, 0, 1'b0, "R7");
        step(1'b0, 0, 1'b0, "R7");
        check_val("R7", 0, 1'b1);

        // R8: clear meets a due update carrying a crossing sample
        step(1'b1, 5000, 1'b0, "R8");
        step(1'b0, 0, 1'b1, "R8");
        check_val("R8", 0, 1'b0);
        step(1'b1, 130, 1'b0, "R8");
        step(1'b0, 0, 1'b0, "R8");
        check_val("R8", 30, 1'b0);

        // R4 / R10: back-to-back maximum samples with zero drift saturate
        base = 16'd0; thr = 24'hFFFFFF;
        for (int i = 0; i < 300; i++) step(1'b1, 65535, 1'b0, "R10");
        step(1'b0, 0, 1'b0, "R4");
        check_val("R4", SMAX, 1'b0);

        // R10: seeded random traffic with clears and parameter changes
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 24) == 0) begin
                base = DATA_W'($urandom % 40000);
                post = DATA_W'($urandom % 2048);
                wt   = WT_W'($urandom % 32);
                thr  = STAT_W'($urandom % (1 << 20));
            end
            step(($urandom % 4) != 0, longint'($urandom % 65536),
                 ($urandom % 64) == 0, "R10");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10: watchdog expired, completed=0 expected completed=1");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule